// File: doc/BRIEF.md
# Parallel Video Scrambler and NRZI Encoder

This block prepares a stream of 10-bit video characters for an external serializer. On every clock it accepts one character and pushes all ten bits through a self-synchronizing scrambler with generator x^9 + x^4 + 1, then through an NRZ-to-NRZI converter. Both stages are unrolled, so ten serial bit-times are resolved in a single clock. The result is a registered 10-bit word. Bit 0 of each character is taken as the earliest bit in time. The scrambler history and the NRZI line level both carry from one character to the next.

Two controls select a raw path. When a bypass control is high, the registered character is copied to the output register, skipping both stages. When the alternate-transport mode is high, the character is also passed raw, and the bypass control is then ignored. On the raw path the encoder history is frozen. Encoding therefore resumes from the state left by the last encoded character. A valid strobe marks which cycles carry a character. When the strobe is low, the output and all history hold.

Top module: `svid_encoder`

## Requirements
- R1: A character presented at clock edge k is captured in an input register and its result appears on `word_o` after edge k+1, giving a two-edge latency. One character is accepted on every edge.
- R2: On the encode path, bits are processed in order from bit 0 (earliest) to bit 9. Each scrambled bit is s[n] = d[n] XOR s[n-4] XOR s[n-9], where s[] is the scrambler's own output history.
- R3: The NRZI stage produces y[n] = s[n] XOR y[n-1], and output bit i of `word_o` is y for input bit i.
- R4: With `alt_mode_i` low and `bypass_i` high on a valid character, `word_o` equals the character unchanged.
- R5: With `alt_mode_i` high on a valid character, `word_o` equals the character unchanged, whatever the level of `bypass_i`.
- R6: When `valid_i` is low, `word_o` keeps its previous value, and the scrambler and NRZI history do not advance.
- R7: An asynchronous low on `rst_ni` clears `word_o`, the scrambler history and the NRZI level to zero. The first encoded character after reset is therefore computed from an all-zero history.
- R8: Raw-path characters (R4, R5) leave the scrambler and NRZI history unchanged. The next encoded character continues from the history of the last encoded one, across any number of raw or idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Character clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Character on `char_i` is valid this cycle |
| char_i | input | 10 | Input character, bit 0 earliest in time |
| bypass_i | input | 1 | Pass the character raw, skipping scrambler and NRZI |
| alt_mode_i | input | 1 | Alternate transport mode: raw pass, bypass ignored |
| word_o | output | 10 | Registered encoded or raw word for the serializer |

## Verification
Each result is due two rising edges after its inputs are applied: one edge fills the input register and the next loads the output register. The history registers update on that second edge as well. The bench drives inputs on falling edges and keeps a two-deep queue of expected words computed by a bit-serial reference model. At every falling edge it compares `word_o` against the entry made two falling edges earlier. Gaps in `valid_i` enter the queue as repeats of the last expected word, so hold behaviour is checked on the same schedule.

// File: rtl/svid_pkg.sv
package svid_pkg;
  localparam int unsigned CHAR_W  = 10;
  localparam int unsigned SCR_LEN = 9;
  localparam int unsigned SCR_TAP = 4;

  typedef enum logic [1:0] {
    PATH_IDLE = 2'd0,
    PATH_RAW  = 2'd1,
    PATH_ENC  = 2'd2
  } path_e;
endpackage

// File: rtl/svid_in_stage.sv
module svid_in_stage
  import svid_pkg::*;
#(
  parameter int unsigned W = CHAR_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] char_i,
  input  logic         bypass_i,
  input  logic         alt_mode_i,
  output logic [W-1:0] char_o,
  output path_e        path_o
);
  logic vld_q, byp_q, alt_q;
  logic [W-1:0] char_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      byp_q  <= 1'b0;
      alt_q  <= 1'b0;
      char_q <= '0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) begin
        byp_q  <= bypass_i;
        alt_q  <= alt_mode_i;
        char_q <= char_i;
      end
    end
  end

  // alternate transport overrides bypass
  always_comb begin
    if (!vld_q)              path_o = PATH_IDLE;
    else if (alt_q || byp_q) path_o = PATH_RAW;
    else                     path_o = PATH_ENC;
  end

  assign char_o = char_q;
endmodule

// File: rtl/svid_scr_stage.sv
module svid_scr_stage #(
  parameter int unsigned W   = 10,
  parameter int unsigned L   = 9,
  parameter int unsigned TAP = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] scr_o,
  output logic [L-1:0] state_o
);
  localparam int unsigned TAP_IDX = TAP - 1;
  localparam int unsigned MSB_IDX = L - 1;

  logic [L-1:0] state_q;
  logic [L-1:0] hist [W+1];
  logic [W-1:0] scr_w;

  assign hist[0] = state_q;

  // hist[i][0] is the most recent scrambled bit
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign scr_w[i]   = data_i[i] ^ hist[i][TAP_IDX] ^ hist[i][MSB_IDX];
    assign hist[i+1]  = {hist[i][L-2:0], scr_w[i]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= '0;
    else if (adv_i) state_q <= hist[W];
  end

  assign scr_o   = scr_w;
  assign state_o = state_q;
endmodule

// File: rtl/svid_nrzi_stage.sv
module svid_nrzi_stage #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] line_o,
  output logic         level_o
);
  logic         level_q;
  logic [W:0]   lvl;

  assign lvl[0] = level_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign lvl[i+1] = data_i[i] ^ lvl[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    level_q <= 1'b0;
    else if (adv_i) level_q <= lvl[W];
  end

  assign line_o  = lvl[W:1];
  assign level_o = level_q;
endmodule

// File: rtl/svid_encoder.sv
module svid_encoder
  import svid_pkg::*;
#(
  parameter int unsigned W   = CHAR_W,
  parameter int unsigned L   = SCR_LEN,
  parameter int unsigned TAP = SCR_TAP
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] char_i,
  input  logic         bypass_i,
  input  logic         alt_mode_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] char_q;
  path_e        path;
  logic         enc_adv;
  logic [W-1:0] scr_w;
  logic [W-1:0] line_w;
  logic [L-1:0] scr_state;
  logic         nrzi_level;
  logic [W-1:0] word_q;

  svid_in_stage #(.W(W)) u_in (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .char_i     (char_i),
    .bypass_i   (bypass_i),
    .alt_mode_i (alt_mode_i),
    .char_o     (char_q),
    .path_o     (path)
  );

  assign enc_adv = (path == PATH_ENC);

  svid_scr_stage #(.W(W), .L(L), .TAP(TAP)) u_scr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (enc_adv),
    .data_i  (char_q),
    .scr_o   (scr_w),
    .state_o (scr_state)
  );

  svid_nrzi_stage #(.W(W)) u_nrzi (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (enc_adv),
    .data_i  (scr_w),
    .line_o  (line_w),
    .level_o (nrzi_level)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else begin
      case (path)
        PATH_ENC: word_q <= line_w;
        PATH_RAW: word_q <= char_q;
        default:  word_q <= word_q;
      endcase
    end
  end

  assign word_o = word_q;
endmodule

// File: rtl/svid_encoder_chk.sv
module svid_encoder_chk #(
  parameter int unsigned W = 10,
  parameter int unsigned L = 9
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [W-1:0] char_i,
  input logic         bypass_i,
  input logic         alt_mode_i,
  input logic [W-1:0] word_o,
  input logic [L-1:0] scr_state_i,
  input logic         nrzi_level_i
);
  logic [1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= 2'd0;
    else if (cyc_q != 2'd2) cyc_q <= cyc_q + 2'd1;
  end

  // R4
  bypass_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd2 && $past(valid_i, 2) && $past(bypass_i, 2) && !$past(alt_mode_i, 2))
      |-> word_o == $past(char_i, 2));

  // R5
  alt_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd2 && $past(valid_i, 2) && $past(alt_mode_i, 2))
      |-> word_o == $past(char_i, 2));

  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd2 && !$past(valid_i, 2)) |-> word_o == $past(word_o));

  // R8
  scr_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 2'd0 && !($past(valid_i) && !$past(bypass_i) && !$past(alt_mode_i)))
      |=> $stable(scr_state_i));

  // R8
  nrzi_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 2'd0 && !($past(valid_i) && !$past(bypass_i) && !$past(alt_mode_i)))
      |=> $stable(nrzi_level_i));
endmodule

bind svid_encoder svid_encoder_chk #(.W(W), .L(L)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .char_i       (char_i),
  .bypass_i     (bypass_i),
  .alt_mode_i   (alt_mode_i),
  .word_o       (word_o),
  .scr_state_i  (scr_state),
  .nrzi_level_i (nrzi_level)
);

// File: tb/svid_encoder_bench.sv
module svid_encoder_bench;
  localparam int unsigned W = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [W-1:0] char_i = '0;
  logic         bypass_i = 1'b0;
  logic         alt_mode_i = 1'b0;
  logic [W-1:0] word_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference model state
  logic [8:0]   m_scr = '0;
  logic         m_lvl = 1'b0;
  logic [W-1:0] m_word = '0;

  // two-deep expected queue
  logic [W-1:0] exp1 = '0, exp2 = '0;
  bit           pend1 = 1'b0, pend2 = 1'b0;
  string        tag1 = "", tag2 = "";

  always #5 clk_i = ~clk_i;

  svid_encoder u_svid_encoder (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .char_i     (char_i),
    .bypass_i   (bypass_i),
    .alt_mode_i (alt_mode_i),
    .word_o     (word_o)
  );

  // bit-serial reference: R2 scrambler then R3 NRZI, bit 0 first
  function automatic logic [W-1:0] ref_encode(input logic [W-1:0] d);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      logic s;
      s     = d[i] ^ m_scr[3] ^ m_scr[8];
      m_scr = {m_scr[7:0], s};
      m_lvl = s ^ m_lvl;
      r[i]  = m_lvl;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: word_o=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // called at a falling edge: check the result due now, then apply a new vector
  task automatic step(input bit v, input bit byp, input bit alt,
                      input logic [W-1:0] ch, input string tag);
    if (pend2) check(tag2, word_o, exp2);
    exp2 = exp1; pend2 = pend1; tag2 = tag1;
    if (v) begin
      if (alt || byp) m_word = ch;
      else            m_word = ref_encode(ch);
    end
    exp1 = m_word; pend1 = 1'b1; tag1 = tag;
    valid_i = v; bypass_i = byp; alt_mode_i = alt; char_i = ch;
    @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'h5eed_0b1d);
    repeat (3) @(negedge clk_i);
    // R7: reset state
    check("R7", word_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R7", word_o, '0);

    // R7/R2: zero data from zero history encodes to zero
    step(1, 0, 0, 10'h000, "R7");
    // R1/R2/R3 directed patterns
    step(1, 0, 0, 10'h3ff, "R2");
    step(1, 0, 0, 10'h001, "R3");
    step(1, 0, 0, 10'h200, "R1");
    // R4 bypass
    step(1, 1, 0, 10'h2a5, "R4");
    // R5 alt mode with and without bypass
    step(1, 0, 1, 10'h15a, "R5");
    step(1, 1, 1, 10'h3c3, "R5");
    // R6 idle gaps with changing data
    step(0, 0, 0, 10'h0f0, "R6");
    step(0, 1, 1, 10'h00f, "R6");
    // R8 encoding resumes from held history
    step(1, 0, 0, 10'h155, "R8");
    step(1, 1, 0, 10'h3ff, "R8");
    step(0, 0, 0, 10'h000, "R8");
    step(1, 0, 0, 10'h155, "R8");

    for (int k = 0; k < 3000; k++) begin
      int unsigned r;
      bit v, b, a;
      string t;
      r = $urandom;
      v = (r[3:0] != 4'd0);
      b = (r[6:4] == 3'd0);
      a = (r[9:7] == 3'd0);
      if (!v)          t = "R6";
      else if (a)      t = "R5";
      else if (b)      t = "R4";
      else             t = "R2";
      step(v, b, a, W'($urandom), t);
    end
    // flush
    step(0, 0, 0, '0, "R6");
    step(0, 0, 0, '0, "R6");
    step(0, 0, 0, '0, "R6");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule